// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block provides the timing backbone of a small microcontroller core. It divides the incoming clock into four non-overlapping phase strobes. One instruction cycle is made of one pass through the four phases, Q1 to Q4. Over these phases it runs a two-stage pipeline. While one instruction executes out of the instruction register, the next word is fetched from a 12-bit-wide program memory.

The sequencer owns the program counter and drives it as the program-memory address. It captures the returned word at the end of Q4 and hands it to the instruction register at the end of the following Q1. It also produces the data-memory strobes: an operand-read enable in Q2 and a destination-write enable in Q4. The execute logic can request a jump by raising a request with a target address during Q4. The sequencer then reloads the counter and turns the word already fetched into a no-op slot, so a jump costs two instruction cycles. Only the low part of the address space holds memory, and every address folds into that range.

Top module: `qfs_fetch_seq`

## Requirements
- R1: `phase_o` is all zeros while `rst_ni` is low. From the first clock after reset is released, exactly one bit is set on every clock. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The first strobe after release is Q1.
- R2: The strobes follow the repeating order Q1, Q2, Q3, Q4, Q1, and so on.
- R3: `imem_addr_o` changes only at the clock edge that ends Q1. Without a redirection it advances by one per instruction cycle.
- R4: The word on `imem_rdata_i` is captured at the edge that ends Q4. At the edge that ends the next Q1 it appears on `ir_o`. `ir_o` changes at no other edge.
- R5: While in reset, `imem_addr_o` is 0, `ir_o` is 0 (the no-op encoding) and `ir_valid_o` is 0. The first instruction cycle after release is a no-op slot that fetches address 0 without incrementing. The word at address 0 becomes valid on `ir_o` in the second instruction cycle.
- R6: `dmem_re_o` is high exactly during Q2 of a cycle in which `ir_valid_o` is high. `dmem_we_o` is high exactly during Q4 of such a cycle. Both are low at all other times.
- R7: If `branch_req_i` is high at the edge that ends Q4 while `ir_valid_o` is high, then at the edge that ends the next Q1 the counter loads `branch_tgt_i` (as sampled at that Q4 edge) in place of the increment. `ir_o` becomes 0 with `ir_valid_o` low for that instruction cycle, so the word already fetched is discarded. The word at the target executes in the instruction cycle after that.
- R8: `branch_req_i` has no effect when it is sampled at an edge that does not end Q4, or while `ir_valid_o` is low.
- R9: `imem_addr_o` is always below 2**IMPL_AW. Incrementing from 2**IMPL_AW-1 gives 0. The target bits at and above IMPL_AW are dropped when a target is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | PC_W | Program counter, used as the program-memory address |
| imem_rdata_i | input | INSN_W | Program-memory word at `imem_addr_o` |
| branch_req_i | input | 1 | Jump request from execute, sampled at the end of Q4 |
| branch_tgt_i | input | PC_W | Jump target address |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| ir_o | output | INSN_W | Instruction register |
| ir_valid_o | output | 1 | Low for a flushed or boot no-op slot |
| dmem_re_o | output | 1 | Data-memory operand-read enable (Q2) |
| dmem_we_o | output | 1 | Data-memory destination-write enable (Q4) |

## Verification
The bench builds the block with its defaults: a 9-bit counter, 8 implemented address bits and 12-bit words. With 256 implemented words, a long straight run carries the counter through the 255-to-0 fold within roughly a thousand clocks. Random 9-bit targets exercise the dropped upper bit. Held and randomly timed jump requests land in non-Q4 phases and in flushed slots. This reaches the ignore cases, and back-to-back jumps on the same execute slot.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  localparam int unsigned NUM_PH = 4;
  localparam int unsigned PH_Q1 = 0;
  localparam int unsigned PH_Q2 = 1;
  localparam int unsigned PH_Q3 = 2;
  localparam int unsigned PH_Q4 = 3;
  typedef logic [NUM_PH-1:0] phase_t;
endpackage

// File: rtl/qfs_phase_gen.sv
module qfs_phase_gen
  import qfs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_t strobe_o
);
  phase_t strobe_q;

  // zero in reset, so the first edge after release enters Q1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= '0;
    else if (strobe_q == '0) strobe_q <= phase_t'(1);
    else strobe_q <= {strobe_q[NUM_PH-2:0], strobe_q[NUM_PH-1]};
  end

  assign strobe_o = strobe_q;
endmodule

// File: rtl/qfs_pc_unit.sv
module qfs_pc_unit #(
  parameter int unsigned PC_W    = 9,
  parameter int unsigned IMPL_AW = 8,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            q1_end_i,
  input  logic            hold_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] tgt_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] AMASK = {PC_W{1'b1}} >> (PC_W - IMPL_AW);

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    if (hold_i)      pc_d = pc_q;
    else if (load_i) pc_d = tgt_i & AMASK;
    else             pc_d = (pc_q + PC_W'(1)) & AMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= RESET_VEC & AMASK;
    else if (q1_end_i) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/qfs_fetch_pipe.sv
module qfs_fetch_pipe
  import qfs_pkg::*;
#(
  parameter int unsigned PC_W   = 9,
  parameter int unsigned INSN_W = 12,
  parameter logic [INSN_W-1:0] NOP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_t            strobe_i,
  input  logic [INSN_W-1:0] rdata_i,
  input  logic              br_req_i,
  input  logic [PC_W-1:0]   br_tgt_i,
  output logic [INSN_W-1:0] ir_o,
  output logic              ir_valid_o,
  output logic              boot_o,
  output logic              redirect_o,
  output logic [PC_W-1:0]   redirect_tgt_o
);
  logic [INSN_W-1:0] fetch_q, ir_q;
  logic              valid_q, boot_q, pend_q;
  logic [PC_W-1:0]   tgt_q;
  logic              kill;

  assign kill = boot_q | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= NOP;
      ir_q    <= NOP;
      valid_q <= 1'b0;
      boot_q  <= 1'b1;
      pend_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      if (strobe_i[PH_Q4]) begin
        fetch_q <= rdata_i;
        // only a live execute slot may redirect
        if (br_req_i && valid_q) begin
          pend_q <= 1'b1;
          tgt_q  <= br_tgt_i;
        end
      end
      if (strobe_i[PH_Q1]) begin
        ir_q    <= kill ? NOP : fetch_q;
        valid_q <= ~kill;
        boot_q  <= 1'b0;
        pend_q  <= 1'b0;
      end
    end
  end

  assign ir_o           = ir_q;
  assign ir_valid_o     = valid_q;
  assign boot_o         = boot_q;
  assign redirect_o     = pend_q;
  assign redirect_tgt_o = tgt_q;
endmodule

// File: rtl/qfs_fetch_seq.sv
module qfs_fetch_seq
  import qfs_pkg::*;
#(
  parameter int unsigned PC_W    = 9,
  parameter int unsigned IMPL_AW = 8,
  parameter int unsigned INSN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [INSN_W-1:0] imem_rdata_i,
  input  logic              branch_req_i,
  input  logic [PC_W-1:0]   branch_tgt_i,
  output logic [3:0]        phase_o,
  output logic [INSN_W-1:0] ir_o,
  output logic              ir_valid_o,
  output logic              dmem_re_o,
  output logic              dmem_we_o
);
  phase_t          strobe;
  logic            boot, redirect;
  logic [PC_W-1:0] redirect_tgt;

  qfs_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_o (strobe)
  );

  qfs_pc_unit #(.PC_W(PC_W), .IMPL_AW(IMPL_AW)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .q1_end_i (strobe[PH_Q1]),
    .hold_i   (boot),
    .load_i   (redirect),
    .tgt_i    (redirect_tgt),
    .pc_o     (imem_addr_o)
  );

  qfs_fetch_pipe #(.PC_W(PC_W), .INSN_W(INSN_W)) u_pipe (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .strobe_i       (strobe),
    .rdata_i        (imem_rdata_i),
    .br_req_i       (branch_req_i),
    .br_tgt_i       (branch_tgt_i),
    .ir_o           (ir_o),
    .ir_valid_o     (ir_valid_o),
    .boot_o         (boot),
    .redirect_o     (redirect),
    .redirect_tgt_o (redirect_tgt)
  );

  assign phase_o   = strobe;
  assign dmem_re_o = strobe[PH_Q2] & ir_valid_o;
  assign dmem_we_o = strobe[PH_Q4] & ir_valid_o;
endmodule

// File: rtl/qfs_fetch_seq_chk.sv
module qfs_fetch_seq_chk #(
  parameter int unsigned PC_W    = 9,
  parameter int unsigned IMPL_AW = 8,
  parameter int unsigned INSN_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   imem_addr_o,
  input logic              branch_req_i,
  input logic [3:0]        phase_o,
  input logic [INSN_W-1:0] ir_o,
  input logic              ir_valid_o,
  input logic              dmem_re_o,
  input logic              dmem_we_o
);
  a_r1_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != '0 |=> $countones(phase_o) == 1);
  a_r1_at_most_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_o));
  a_r2_q1_q2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[0] |=> phase_o[1]);
  a_r2_q2_q3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[1] |=> phase_o[2]);
  a_r2_q3_q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[2] |=> phase_o[3]);
  a_r2_q4_q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[3] |=> phase_o[0]);
  a_r3_pc_moves_at_q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |=> $stable(imem_addr_o));
  a_r4_ir_moves_at_q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |=> $stable(ir_o) && $stable(ir_valid_o));
  a_r6_read_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_re_o |-> phase_o[1] && ir_valid_o);
  a_r6_write_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> phase_o[3] && ir_valid_o);
  a_r7_flush_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[3] && branch_req_i && ir_valid_o |-> ##2 (!ir_valid_o && ir_o == '0));
  a_r9_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_o < PC_W'(1 << IMPL_AW));
endmodule

bind qfs_fetch_seq qfs_fetch_seq_chk #(.PC_W(PC_W), .IMPL_AW(IMPL_AW), .INSN_W(INSN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_addr_o  (imem_addr_o),
  .branch_req_i (branch_req_i),
  .phase_o      (phase_o),
  .ir_o         (ir_o),
  .ir_valid_o   (ir_valid_o),
  .dmem_re_o    (dmem_re_o),
  .dmem_we_o    (dmem_we_o)
);

// File: tb/qfs_fetch_seq_test.sv
`timescale 1ns/1ps
module qfs_fetch_seq_test;
  localparam int unsigned PC_W = 9, IMPL_AW = 8, INSN_W = 12;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [PC_W-1:0]   imem_addr;
  logic [INSN_W-1:0] imem_rdata;
  logic              br_req;
  logic [PC_W-1:0]   br_tgt;
  logic [3:0]        phase;
  logic [INSN_W-1:0] ir;
  logic              ir_valid, re, we;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [INSN_W-1:0] mem_word(logic [PC_W-1:0] a);
    int unsigned v;
    v = (int'(a) * 397 + 1) ^ 32'h5A3 ^ (int'(a) << 4);
    return INSN_W'(v);
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  qfs_fetch_seq #(.PC_W(PC_W), .IMPL_AW(IMPL_AW), .INSN_W(INSN_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .branch_req_i(br_req), .branch_tgt_i(br_tgt), .phase_o(phase), .ir_o(ir),
    .ir_valid_o(ir_valid), .dmem_re_o(re), .dmem_we_o(we)
  );

  // reference state derived from the requirements
  int                m_ph;
  logic [PC_W-1:0]   m_pc, m_tgt;
  logic [INSN_W-1:0] m_fetch, m_ir;
  logic              m_val, m_boot, m_pend;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [PC_W-1:0] fold(logic [PC_W-1:0] a);
    return a & PC_W'((1 << IMPL_AW) - 1);
  endfunction

  task automatic compare_all();
    logic [3:0] eph;
    eph = (m_ph < 0) ? 4'b0 : 4'(1 << m_ph);
    chk("R1 R2 phase", 32'(phase), 32'(eph));
    chk("R3 R9 addr", 32'(imem_addr), 32'(m_pc));
    chk("R4 R7 ir", 32'(ir), 32'(m_ir));
    chk("R5 R7 valid", 32'(ir_valid), 32'(m_val));
    chk("R6 read enable", 32'(re), 32'(m_ph == 1 && m_val));
    chk("R6 write enable", 32'(we), 32'(m_ph == 3 && m_val));
  endtask

  // advance the model by one clock using the inputs the design will sample
  task automatic model_step();
    logic kill;
    kill = m_boot | m_pend;
    if (m_ph == 0) begin
      m_ir  = kill ? '0 : m_fetch;
      m_val = ~kill;
      m_pc  = m_boot ? m_pc : (m_pend ? fold(m_tgt) : fold(m_pc + 1'b1));
      m_boot = 0;
      m_pend = 0;
    end else if (m_ph == 3) begin
      m_fetch = mem_word(m_pc);
      // R8: requests outside Q4 or in a dead slot leave no trace
      if (br_req && m_val) begin
        m_pend = 1;
        m_tgt  = br_tgt;
      end
    end
    m_ph = (m_ph + 1) % 4;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_ni = 1'b0; br_req = 1'b0; br_tgt = '0;
    m_ph = -1; m_pc = '0; m_tgt = '0; m_fetch = '0; m_ir = '0;
    m_val = 0; m_boot = 1; m_pend = 0;
    repeat (3) @(negedge clk);
    // R5 / R1: reset state
    compare_all();
    rst_ni = 1'b1;

    for (int i = 0; i < 6000; i++) begin
      compare_all();
      br_req = 1'b0;
      if (i == 1100 && m_ph == 3) begin end
      if (i >= 1200 && i < 1260) begin
        // R9: target with upper bit set, taken at the first live Q4
        br_req = 1'b1;
        br_tgt = 9'h1F0;
      end else if (i >= 1400 && i < 1440) begin
        // R7/R8: request held across every phase and the flushed slot
        br_req = 1'b1;
        br_tgt = 9'(i);
      end else if (i >= 1500) begin
        // R8: random requests, most not on Q4
        br_req = ($urandom % 6) == 0;
        br_tgt = PC_W'($urandom);
      end
      model_step();
      @(negedge clk);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule